// File: doc/BRIEF.md
# Two-Wire Register Port Slave

This block lets an external master reach a bank of 64 eight-bit registers over a two-wire serial bus (one clock line, one open-drain data line). The block runs on a fast system clock. It passes both bus lines through a two-flop synchronizer and a glitch filter. It then recognises START and STOP conditions from data-line edges that occur while the bus clock is high. Between those markers it collects bytes MSB first and answers each byte that it accepts with an acknowledge in the ninth clock.

A transaction opens with a device address byte that carries the seven-bit bus address and a direction bit. For a write, the next byte is a register address byte: bit 6 selects auto-increment and bits 5:0 give the register index. Without auto-increment every data byte needs its own register address byte in front of it. With auto-increment a single address is followed by a run of data bytes that land in consecutive registers. A read sets the index with a write, then issues a repeated START with the direction bit set. The block shifts out register contents for as long as the master acknowledges.

The data output is an enable: when it is high, the pad pulls the line low. The lowest bit of the bus address comes from a strap input, so two of these blocks can share one bus.

Top module: `regport_slave`

## Requirements
- R1: After asynchronous reset the data-line pull-down is off and all 64 registers read back as 0x00.
- R2: A START (data falls while the bus clock is high) restarts byte reception at the device address byte. A STOP (data rises while the bus clock is high) returns the block to idle and releases the line, even in the middle of a byte. In idle, bytes are not acknowledged and do not write.
- R3: In the device address byte, bits 7:1 are compared with {DEV_ID, strap} and bit 0 is the direction (0 write, 1 read). On a match the block pulls the line low throughout the ninth clock.
- R4: A device address byte that does not match is not acknowledged. Until the next START the block drives nothing and writes no register.
- R5: A register address byte is acknowledged. Its bit 7 is ignored, bit 6 is the auto-increment flag, and bits 5:0 set the register index.
- R6: With auto-increment clear, a data byte is written to the indexed register and acknowledged, and the byte after it is taken as a new register address byte.
- R7: With auto-increment set, each data byte is written and the index then advances by one, wrapping from 63 to 0.
- R8: After a matching read address byte, the block shifts out the indexed register MSB first. If the master acknowledges, it sends another byte: the next register when auto-increment is set, the same register when it is clear. If the master does not acknowledge, the block releases the line until the next START.
- R9: The pull-down enable changes only while the bus clock is low, except in response to a START or a STOP.
- R10: A pulse shorter than FILT_LEN system clocks on either bus line has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap_i | input | 1 | Least significant bit of the seven-bit bus address |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull the data line low when high |

## Verification
Every response is due a fixed number of system clocks after the bus edge that causes it. That number is two synchronizer flops, plus FILT_LEN filter cycles, plus one edge register, plus the state register: about eight clocks with the defaults. The bench therefore moves the bus in quarter-bit steps of twelve system clocks. It samples acknowledges and read bits one quarter after the bus clock rises, when the response has long settled. It samples read bits a second time just before the bus clock falls, to show that they held while the clock was high. Glitches last two system clocks, so they stay below the filter threshold, and each glitch is followed by a read-back of the register it could have corrupted.

// File: rtl/regport_slave.sv
module regport_slave #(
  parameter logic [5:0] DEV_ID   = 6'b111010,
  parameter int         FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_strap_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int AW   = 6;
  localparam int NREG = 1 << AW;
  localparam int FW   = $clog2(FILT_LEN + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_REG, ST_WR, ST_RD, ST_IGN} st_t;

  logic [1:0] raw, flt, flt_d;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic q1, q2, qf;
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q1  <= 1'b1;
        q2  <= 1'b1;
        qf  <= 1'b1;
        cnt <= '0;
      end else begin
        q1 <= raw[g];
        q2 <= q1;
        if (q2 == qf) cnt <= '0;
        else if (cnt == FW'(FILT_LEN - 1)) begin
          qf  <= q2;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign flt[g] = qf;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flt_d <= 2'b11;
    else        flt_d <= flt;

  logic scl_f, sda_f, scl_d, sda_d;
  assign {scl_f, sda_f} = flt;
  assign {scl_d, sda_d} = flt_d;

  logic rise, fall, start_ev, stop_ev;
  assign rise     = scl_f & ~scl_d;
  assign fall     = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txsh;
  logic [AW-1:0] ptr;
  logic          auto_f, rw_f, mack, ack_drv, tx_en;
  logic [7:0]    regs [NREG];

  logic dev_match, active;
  assign dev_match = shreg[7:1] == {DEV_ID, addr_strap_i};
  assign active    = (st != ST_IDLE) && (st != ST_IGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      auto_f  <= 1'b0;
      rw_f    <= 1'b0;
      mack    <= 1'b0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start_ev) begin
      st      <= ST_DEV;
      bitcnt  <= '0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
    end else if (stop_ev) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
    end else if (active) begin
      if (rise) begin
        if (bitcnt < 4'd8)  shreg <= {shreg[6:0], sda_f};
        if (bitcnt == 4'd8) mack  <= ~sda_f;
        if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (fall) begin
        if (bitcnt == 4'd8) begin
          unique case (st)
            ST_DEV: if (dev_match) begin
                      ack_drv <= 1'b1;
                      rw_f    <= shreg[0];
                    end else st <= ST_IGN;
            ST_REG: begin
                      ack_drv <= 1'b1;
                      auto_f  <= shreg[6];
                      ptr     <= shreg[AW-1:0];
                    end
            ST_WR:  begin
                      ack_drv   <= 1'b1;
                      regs[ptr] <= shreg;
                      if (auto_f) ptr <= ptr + 1'b1;
                    end
            ST_RD:  begin
                      tx_en <= 1'b0;
                      if (auto_f) ptr <= ptr + 1'b1;
                    end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          ack_drv <= 1'b0;
          bitcnt  <= '0;
          unique case (st)
            ST_DEV: if (rw_f) begin
                      st    <= ST_RD;
                      txsh  <= regs[ptr];
                      tx_en <= 1'b1;
                    end else st <= ST_REG;
            ST_REG: st <= ST_WR;
            ST_WR:  st <= auto_f ? ST_WR : ST_REG;
            ST_RD:  if (mack) begin
                      txsh  <= regs[ptr];
                      tx_en <= 1'b1;
                    end else st <= ST_IGN;
            default: ;
          endcase
        end else if (bitcnt != 4'd0 && st == ST_RD) begin
          txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe_o = ack_drv | (tx_en & ~txsh[7]);

  AST_OE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_d && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe_o)); // R9
  AST_IGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !sda_oe_o); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE && !sda_oe_o)); // R2
  AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_DEV && bitcnt == 4'd0)); // R2
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bitcnt == 4'd8 && st == ST_WR && auto_f) |=> (ptr == $past(ptr) + 6'd1)); // R7

endmodule

// File: tb/regport_slave_tb.sv
module regport_slave_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 12;
  localparam int         WD_CYCLES  = 150000;
  localparam logic [5:0] DEV_ID     = 6'b111010;
  localparam logic [7:0] DEVW       = 8'hEA;
  localparam logic [7:0] DEVR       = 8'hEB;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b1;
  logic tb_scl = 1'b1, tb_sda = 1'b1;
  logic sda_oe, sda_line;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_line = tb_sda & ~sda_oe;

  regport_slave #(.DEV_ID(DEV_ID), .FILT_LEN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap_i(strap),
    .scl_i(tb_scl), .sda_i(sda_line), .sda_oe_o(sda_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(); tb_sda = 1'b1; wq(); tb_scl = 1'b1; wq(); tb_sda = 1'b0; wq(); tb_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); tb_sda = 1'b0; wq(); tb_scl = 1'b1; wq(); tb_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wq(); tb_sda = b[i];
      if (glitch && i == 4) begin
        repeat (3) @(negedge clk); tb_scl = 1'b1;
        repeat (2) @(negedge clk); tb_scl = 1'b0;
        repeat (Q - 5) @(negedge clk);
      end else wq();
      tb_scl = 1'b1;
      if (glitch && i == 3) begin
        repeat (3) @(negedge clk); tb_sda = 1'b0;
        repeat (2) @(negedge clk); tb_sda = 1'b1;
        repeat (Q - 5) @(negedge clk);
      end else wq();
      wq(); tb_scl = 1'b0;
    end
    wq(); tb_sda = 1'b1; wq(); tb_scl = 1'b1; wq();
    ack = (sda_line == 1'b0);
    wq(); tb_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d, output bit held);
    logic a;
    held = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); tb_sda = 1'b1; wq(); tb_scl = 1'b1; wq();
      a = sda_line;
      wq();
      if (sda_line !== a) held = 1'b0;
      d[i] = a;
      tb_scl = 1'b0;
    end
    wq(); tb_sda = mack ? 1'b0 : 1'b1; wq(); tb_scl = 1'b1; wq(); wq(); tb_scl = 1'b0;
  endtask

  task automatic send_ack(input string req, input logic [7:0] b, input logic exp_ack);
    logic ack;
    send_byte(b, 1'b0, ack);
    check(req, ack, exp_ack);
  endtask

  task automatic read_reg(input logic [5:0] addr, output logic [7:0] d);
    bit held;
    bus_start();
    send_ack("R3 dev ack", DEVW, 1'b1);
    send_ack("R5 reg ack", {2'b00, addr}, 1'b1);
    bus_start();
    send_ack("R8 read dev ack", DEVR, 1'b1);
    recv_byte(1'b0, d, held);
    check("R9 read bit held", held, 1'b1);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 oe after reset", sda_oe, 1'b0);
    read_reg(6'd0, d);  check("R1 reg0", d, 8'h00);
    read_reg(6'd63, d); check("R1 reg63", d, 8'h00);
  endtask

  task automatic t_alt_write();
    logic [7:0] d;
    bus_start();
    send_ack("R3 write dev ack", DEVW, 1'b1);
    send_ack("R5 reg5 ack", 8'h05, 1'b1);
    send_ack("R6 data ack", 8'hA5, 1'b1);
    send_ack("R5 reg9 bit7 set ack", 8'h89, 1'b1);
    send_ack("R6 data2 ack", 8'h3C, 1'b1);
    bus_stop();
    read_reg(6'd5, d); check("R6 reg5", d, 8'hA5);
    read_reg(6'd9, d); check("R5 reg9 bit7 ignored", d, 8'h3C);
    read_reg(6'd6, d); check("R6 no advance", d, 8'h00);
  endtask

  task automatic t_auto_write();
    logic [7:0] d;
    bit held;
    bus_start();
    send_ack("R3 dev ack", DEVW, 1'b1);
    send_ack("R5 auto reg ack", 8'h7E, 1'b1);
    send_ack("R7 data62 ack", 8'h11, 1'b1);
    send_ack("R7 data63 ack", 8'h22, 1'b1);
    send_ack("R7 data0 ack", 8'h33, 1'b1);
    bus_stop();
    read_reg(6'd0, d); check("R7 wrap to reg0", d, 8'h33);
    bus_start();
    send_ack("R3 dev ack", DEVW, 1'b1);
    send_ack("R5 auto reg ack", 8'h7E, 1'b1);
    bus_start();
    send_ack("R8 dev read ack", DEVR, 1'b1);
    recv_byte(1'b1, d, held); check("R8 auto read 62", d, 8'h11);
    check("R9 held", held, 1'b1);
    recv_byte(1'b1, d, held); check("R8 auto read 63", d, 8'h22);
    recv_byte(1'b0, d, held); check("R7 auto read wrap 0", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_alt_read();
    logic [7:0] d;
    bit held;
    bus_start();
    send_ack("R3 dev ack", DEVW, 1'b1);
    send_ack("R5 reg ack", 8'h05, 1'b1);
    bus_start();
    send_ack("R8 dev read ack", DEVR, 1'b1);
    recv_byte(1'b1, d, held); check("R8 alt read first", d, 8'hA5);
    recv_byte(1'b0, d, held); check("R8 alt read repeats", d, 8'hA5);
    wq(); wq();
    check("R8 released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic [7:0] d;
    bus_start();
    send_ack("R4 wrong dev nack", 8'hE8, 1'b0);
    send_ack("R4 reg ignored", 8'h01, 1'b0);
    send_ack("R4 data ignored", 8'h77, 1'b0);
    bus_stop();
    read_reg(6'd1, d); check("R4 reg1 untouched", d, 8'h00);
    strap = 1'b0;
    bus_start();
    send_ack("R3 strap0 dev ack", 8'hE8, 1'b1);
    send_ack("R5 reg ack", 8'h02, 1'b1);
    send_ack("R6 data ack", 8'h42, 1'b1);
    bus_stop();
    strap = 1'b1;
    read_reg(6'd2, d); check("R3 strap write landed", d, 8'h42);
  endtask

  task automatic t_stop_mid();
    logic [7:0] d;
    bus_start();
    send_ack("R3 dev ack", DEVW, 1'b1);
    send_ack("R5 reg ack", 8'h0A, 1'b1);
    for (int i = 0; i < 3; i++) begin
      wq(); tb_sda = 1'b1; wq(); tb_scl = 1'b1; wq(); wq(); tb_scl = 1'b0;
    end
    bus_stop();
    check("R2 released after stop", sda_oe, 1'b0);
    tb_scl = 1'b0;
    send_ack("R2 idle no ack", DEVW, 1'b0);
    send_ack("R2 idle no ack data", 8'h0A, 1'b0);
    bus_stop();
    read_reg(6'd10, d); check("R2 reg10 untouched", d, 8'h00);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    logic ack;
    bus_start();
    send_ack("R3 dev ack", DEVW, 1'b1);
    send_ack("R5 reg ack", 8'h0C, 1'b1);
    send_byte(8'h5A, 1'b1, ack);
    check("R10 glitched byte ack", ack, 1'b1);
    bus_stop();
    read_reg(6'd12, d); check("R10 reg12 value", d, 8'h5A);
    read_reg(6'd13, d); check("R10 reg13 untouched", d, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_alt_write();
    t_auto_write();
    t_alt_read();
    t_mismatch();
    t_stop_mid();
    t_glitch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule